// File: doc/BRIEF.md
# Write-Protection Boundary Controller

This block keeps the state that decides which part of a serial memory array may still be programmed. It holds a boundary address, a protection flag and a one-time lock bit. Every address at or above the boundary is write-protected while the flag is 0. A flag of 1 means nothing is protected by the boundary.

A command engine sits next to the block. It decodes the serial instructions and presents each completed instruction as a one-cycle strobe with an operation code and an address. It also supplies the two protection pin levels and the state of its write-enable latch. The block returns three things: a protected/unprotected answer for any probe address, a permit for the fill-whole-array instruction, and a serial readback stream of the register. It also returns a flag that says whether busy/ready status may be shown on the data output.

The modifying instructions take effect only when an arming instruction came directly before them. One instruction locks the register permanently. The registers are plain flops that are initialised by the power-on reset.

Top module: `wp_boundary_ctrl`

## Requirements
- R1: `is_protected` is 1 exactly when the flag is 0 and `chk_addr` is greater than or equal to the stored boundary (unsigned compare).
- R2: An armed, unlocked protect-write (`cmd_op` = 2) with `pre_pin` and `w_pin` high stores `cmd_addr` as the boundary and sets the flag to 0.
- R3: An armed, unlocked protect-clear (`cmd_op` = 3) with `pre_pin` and `w_pin` high sets the boundary to all ones and the flag to 1.
- R4: An arm instruction (`cmd_op` = 1) arms the block only when `wen_latch`, `pre_pin` and `w_pin` are all high. It never changes the boundary or the flag.
- R5: A protect-write, protect-clear or lock instruction that is not armed, or that arrives with `pre_pin` or `w_pin` low, changes no state.
- R6: The arming is dropped after every completed instruction other than a successful arm. This includes rejected instructions, reads and other codes (`cmd_op` = 0, 6, 7).
- R7: An armed lock instruction (`cmd_op` = 4) with both pins high sets the lock bit. Once the lock bit is set, the boundary and the flag never change again.
- R8: `status_en` is 1 while the lock bit is clear and 0 once it is set.
- R9: `wrall_ok` equals the protection flag.
- R10: A protect-read (`cmd_op` = 5) with `pre_pin` high loads the readback stream. `rd_bit` then shows a dummy 0, then the boundary bits MSB first, then the flag. Each cycle with `rd_shift` high advances one bit, and zeros follow the last bit. A protect-read with `pre_pin` low loads nothing.
- R11: After reset the boundary is all ones, the flag is 1, the block is unlocked and unarmed, and `rd_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_valid | input | 1 | One-cycle strobe: an instruction has completed |
| cmd_op | input | 3 | Operation code of the completed instruction |
| cmd_addr | input | ADDR_W | Address field of the instruction |
| pre_pin | input | 1 | Protection-enable pin level |
| w_pin | input | 1 | Write-enable pin level |
| wen_latch | input | 1 | Write-enable latch state from the command engine |
| chk_addr | input | ADDR_W | Address to classify |
| is_protected | output | 1 | `chk_addr` lies in the protected region |
| wrall_ok | output | 1 | Fill-whole-array instruction permitted |
| status_en | output | 1 | Busy/ready status may be driven |
| rd_shift | input | 1 | Advance the readback stream by one bit |
| rd_bit | output | 1 | Current readback bit |

## Verification
Boundary probes sit at the boundary, one below it and at the top address. They separate a correct greater-or-equal compare from a strict compare or an inverted flag. The arming tests send an arm that is valid, one that lacks the write-enable latch, one followed by an unrelated instruction and one followed by a rejected arm. These tests separate "armed by the instruction directly before" from "armed at some earlier time". A long run of random operation codes and pin levels, compared every cycle against a behavioural model, covers the lock and the readback stream in orders the directed steps do not reach.

// File: rtl/wp_boundary_ctrl.sv
module wp_boundary_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pre_pin,
  input  logic              w_pin,
  input  logic              wen_latch,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              is_protected,
  output logic              wrall_ok,
  output logic              status_en,
  input  logic              rd_shift,
  output logic              rd_bit
);
  localparam int SH_W = ADDR_W + 2;
  localparam logic [2:0] OP_ARM = 3'd1, OP_WR = 3'd2, OP_CLR = 3'd3,
                         OP_LOCK = 3'd4, OP_RD = 3'd5;

  logic [ADDR_W-1:0] boundary;
  logic              flag, locked, armed;
  logic [SH_W-1:0]   rd_sh;

  wire pins_ok = pre_pin & w_pin;
  wire mod_ok  = cmd_valid & armed & pins_ok & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boundary <= '1;
      flag     <= 1'b1;
      locked   <= 1'b0;
      armed    <= 1'b0;
    end else if (cmd_valid) begin
      armed <= (cmd_op == OP_ARM) & pins_ok & wen_latch;
      if (mod_ok) begin
        case (cmd_op)
          OP_WR:   begin boundary <= cmd_addr; flag <= 1'b0; end
          OP_CLR:  begin boundary <= '1;       flag <= 1'b1; end
          OP_LOCK: locked <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_sh <= '0;
    else if (cmd_valid && cmd_op == OP_RD && pre_pin)
      rd_sh <= {1'b0, boundary, flag};
    else if (rd_shift)
      rd_sh <= {rd_sh[SH_W-2:0], 1'b0};
  end

  assign is_protected = ~flag & (chk_addr >= boundary);
  assign wrall_ok     = flag;
  assign status_en    = ~locked;
  assign rd_bit       = rd_sh[SH_W-1];
endmodule

module wp_boundary_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              pre_pin,
  input logic              w_pin,
  input logic              wen_latch,
  input logic              armed,
  input logic              is_protected,
  input logic              wrall_ok,
  input logic              status_en
);
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_en |=> !status_en);
  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_en |=> $stable(wrall_ok));
  assert_clear_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 && armed && pre_pin && w_pin && status_en |=> wrall_ok && !is_protected);
  assert_write_drops_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 && armed && pre_pin && w_pin && status_en |=> !wrall_ok);
  assert_unarmed_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && !armed |=> $stable(wrall_ok));
  assert_arm_needs_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 && !(wen_latch && pre_pin && w_pin) |=> !armed);
  assert_arm_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op != 3'd1 |=> !armed);
  assert_flag_opens_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrall_ok |-> !is_protected);
endmodule

bind wp_boundary_ctrl wp_boundary_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pre_pin(pre_pin), .w_pin(w_pin), .wen_latch(wen_latch), .armed(armed),
  .is_protected(is_protected), .wrall_ok(wrall_ok), .status_en(status_en)
);

// File: tb/wp_boundary_ctrl_tb_top.sv
`timescale 1ns/1ps
module wp_boundary_ctrl_tb_top;
  localparam int AW = 8;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, pre_pin = 0, w_pin = 0, wen_latch = 0, rd_shift = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, chk_addr = 0;
  logic is_protected, wrall_ok, status_en, rd_bit;

  always #10 clk = ~clk;

  wp_boundary_ctrl #(.ADDR_W(AW)) dut_i (.*);

  int checks = 0, fails = 0, cycles = 0;
  int m_bound = TOP;
  bit m_flag = 1, m_lock = 0, m_armed = 0;
  bit m_q[$];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_bound = TOP; m_flag = 1; m_lock = 0; m_armed = 0; m_q = {};
    end else begin
      if (cmd_valid) begin
        if (m_armed && pre_pin && w_pin && !m_lock) begin
          if (cmd_op == 2) begin m_bound = cmd_addr; m_flag = 0; end
          if (cmd_op == 3) begin m_bound = TOP; m_flag = 1; end
          if (cmd_op == 4) m_lock = 1;
        end
      end
      if (cmd_valid && cmd_op == 5 && pre_pin) begin
        m_q = {};
        m_q.push_back(1'b0);
        for (int i = AW - 1; i >= 0; i--) m_q.push_back(1'((m_bound >> i) & 1));
        m_q.push_back(m_flag);
      end else if (rd_shift && m_q.size() > 0) begin
        void'(m_q.pop_front());
      end
      if (cmd_valid) m_armed = (cmd_op == 1) && pre_pin && w_pin && wen_latch;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R1 per-cycle", is_protected, (!m_flag && chk_addr >= m_bound));
    check("R9 per-cycle", wrall_ok, m_flag);
    check("R8 per-cycle", status_en, !m_lock);
    check("R10 per-cycle", rd_bit, m_q.size() > 0 ? m_q[0] : 0);
  end

  task automatic cmd(int op, int addr, bit pre, bit w, bit wen);
    @(negedge clk); #2;
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(addr);
    pre_pin = pre; w_pin = w; wen_latch = wen;
    @(negedge clk); #2;
    cmd_valid = 0;
  endtask

  task automatic probe(string tag, int a, bit exp);
    @(negedge clk); #2 chk_addr = AW'(a);
    #1 check(tag, is_protected, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    check("R11 reset flag", wrall_ok, 1);
    check("R11 reset unlocked", status_en, 1);
    check("R11 reset rd_bit", rd_bit, 0);
    probe("R11 reset top unprotected", TOP, 0);

    cmd(2, 8'h20, 1, 1, 1);
    check("R5 unarmed write ignored", wrall_ok, 1);
    cmd(1, 0, 1, 1, 0);
    check("R4 arm keeps flag", wrall_ok, 1);
    cmd(2, 8'h20, 1, 1, 1);
    check("R4 arm without latch", wrall_ok, 1);

    cmd(1, 0, 1, 1, 1);
    cmd(2, 8'h40, 1, 1, 1);
    check("R2 flag dropped", wrall_ok, 0);
    probe("R1 below boundary", 8'h3F, 0);
    probe("R1 at boundary", 8'h40, 1);
    probe("R1 top", TOP, 1);

    cmd(5, 0, 1, 0, 0);
    begin
      int exp_bits[$];
      exp_bits.push_back(0);
      for (int i = AW - 1; i >= 0; i--) exp_bits.push_back((8'h40 >> i) & 1);
      exp_bits.push_back(0);
      foreach (exp_bits[k]) begin
        #1 check("R10 readback bit", rd_bit, exp_bits[k]);
        @(negedge clk); #2 rd_shift = 1;
        @(negedge clk); #2 rd_shift = 0;
      end
      #1 check("R10 tail zero", rd_bit, 0);
    end
    cmd(5, 0, 0, 1, 1);
    #1 check("R10 pre low no load", rd_bit, 0);

    cmd(1, 0, 1, 1, 1);
    cmd(0, 0, 1, 1, 1);
    cmd(3, 0, 1, 1, 1);
    check("R6 other op cancels arm", wrall_ok, 0);
    cmd(1, 0, 1, 1, 1);
    cmd(1, 0, 0, 1, 1);
    cmd(3, 0, 1, 1, 1);
    check("R6 rejected arm cancels", wrall_ok, 0);
    cmd(1, 0, 1, 1, 1);
    cmd(3, 0, 1, 0, 1);
    check("R5 w low ignored", wrall_ok, 0);

    cmd(1, 0, 1, 1, 1);
    cmd(3, 0, 1, 1, 1);
    check("R3 clear sets flag", wrall_ok, 1);
    probe("R3 top open", TOP, 0);

    cmd(1, 0, 1, 1, 1);
    cmd(2, 8'h10, 1, 1, 1);
    cmd(1, 0, 1, 1, 1);
    cmd(4, 0, 1, 1, 1);
    check("R8 locked", status_en, 0);
    cmd(1, 0, 1, 1, 1);
    cmd(3, 0, 1, 1, 1);
    check("R7 clear after lock", wrall_ok, 0);
    probe("R7 boundary kept", 8'h10, 1);
    probe("R7 below kept", 8'h0F, 0);

    rst_n = 0;
    @(negedge clk); #2 rst_n = 1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); #2;
      cmd_valid = ($urandom_range(0, 1) == 1);
      cmd_op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) cmd_op = 3'd1;
      if (cmd_op == 3'd4 && $urandom_range(0, 9) != 0) cmd_op = 3'd2;
      cmd_addr = AW'($urandom);
      pre_pin = ($urandom_range(0, 4) != 0);
      w_pin = ($urandom_range(0, 4) != 0);
      wen_latch = ($urandom_range(0, 4) != 0);
      rd_shift = $urandom_range(0, 1);
      chk_addr = AW'($urandom);
    end
    @(negedge clk); #2 cmd_valid = 0; rd_shift = 0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule